// File: doc/BRIEF.md
# Interrupt Pending and Mask Unit

This block holds the pending state of up to 64 interrupt lines and decides when the processor must be woken. Peripherals reach it in two ways: one-cycle event pulses, and level lines that count as a new event only on a low-to-high transition. For every line the unit keeps a raw pending bit, which is recorded whatever the mask says, and an enabled-pending bit, which is seen by the downstream priority selector. Because the two are kept apart, a line that fires while it is masked is remembered and becomes enabled-pending as soon as software enables it.

Software-side control arrives as plain strobes that carry a line index. These strobes enable, disable or clear a single line, clear every line, clear only the enabled lines, re-check a level line when its handler returns, and write a global lock. The lock holds back wake-ups but never pending. The previous lock value is returned on each lock write, so nested critical sections can restore it. A separate hard-fault event gets past the lock for exactly one wake. The wake output is a registered pulse, one cycle wide for each request.

Top module: `irq_pend_unit`

## Requirements
- R1: A pulse event on a line sets its raw pending bit one cycle later. It sets the line's enabled-pending bit only if the line's mask bit, after that cycle's enable or disable strobe, is 1.
- R2: An enable strobe sets the line's mask bit. If the line's raw bit is set, or is set in the same cycle, the enabled-pending bit is set at once, and a wake follows in the next cycle when the lock is clear. A disable strobe clears only the mask bit and leaves an enabled-pending bit already set untouched.
- R3: A level line pends only on a 0-to-1 transition between two sampled cycles. A line held high does not pend again after it has been cleared.
- R4: A re-evaluate strobe sets the raw bit of the indexed line if its level input is 1 in that cycle. It sets the enabled-pending bit as well when the line is unmasked. It causes no wake.
- R5: A clear-line strobe removes both the raw bit and the enabled-pending bit of that line.
- R6: A clear-all strobe zeroes both vectors. A clear-enabled strobe zeroes the enabled-pending vector and removes raw bits only where the mask bit is 1.
- R7: While the lock is 1, events still pend, but no wake is produced except by the hard-fault event. A lock write of 0 over a lock of 1, while any enabled-pending bit is 1, produces a wake in the next cycle.
- R8: A pulse event or a level rising edge produces a wake in the next cycle when the lock is clear, even if the line is masked.
- R9: A hard-fault event produces one wake in the next cycle regardless of the lock. A later event while locked produces none.
- R10: When a clear and a set hit the same line in one cycle, the clear wins. When an enable and a disable hit the same line, the disable wins.
- R11: On each lock write, the previous-lock output takes the lock value held before that write, and the lock output takes the new value.
- R12: After reset, all vectors, the lock, the previous-lock output and the wake are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | NUM_LINES | Per-line event pulses |
| lvl_in | input | NUM_LINES | Per-line level inputs |
| hard_evt | input | 1 | Hard-fault event that gets past the lock |
| en_stb | input | 1 | Enable-line strobe |
| en_idx | input | IDX_W | Line to enable |
| dis_stb | input | 1 | Disable-line strobe |
| dis_idx | input | IDX_W | Line to disable |
| clr_stb | input | 1 | Clear-line strobe |
| clr_idx | input | IDX_W | Line to clear |
| clr_all | input | 1 | Clear every line |
| clr_enabled | input | 1 | Clear enabled lines only |
| reeval_stb | input | 1 | Handler-exit re-evaluate strobe |
| reeval_idx | input | IDX_W | Line to re-evaluate |
| lock_stb | input | 1 | Lock write strobe |
| lock_val | input | 1 | New lock value |
| raw_pend | output | NUM_LINES | Raw pending vector |
| act_pend | output | NUM_LINES | Enabled-pending vector |
| mask_o | output | NUM_LINES | Per-line enable mask |
| wake | output | 1 | Wake request pulse |
| lock_o | output | 1 | Current lock |
| lock_prev | output | 1 | Lock value before the last write |

## Verification
Directed sequences come first. They separate a masked line from an unmasked one when a pulse arrives, and an enable of an already pending line from one of a clean line. They also separate a lock release with work waiting from a release with none, and a level line's first edge from the same line held high. Clear and set, and enable and disable, are driven onto the same line in the same cycle to show which one wins. After that, long runs draw pulses, level toggles and strobes at random from a fixed seed, so commands overlap in ways no directed case lists. Every cycle, all outputs are compared against a behavioural model in the bench.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
  localparam int MAX_LINES = 64;

  typedef struct packed {
    logic set_evt;   // hardware event or re-evaluate hit
    logic en;
    logic dis;
    logic clr;
    logic clr_en;    // clear enabled lines only
    logic clr_all;
  } line_ctl_t;
endpackage

// File: rtl/irq_level_edge.sv
module irq_level_edge #(
  parameter int NUM_LINES = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] lvl_in,
  output logic [NUM_LINES-1:0] rise_o
);
  logic [NUM_LINES-1:0] lvl_d;

  always_ff @(posedge clk) begin
    if (rst) lvl_d <= '0;
    else     lvl_d <= lvl_in;
  end

  assign rise_o = lvl_in & ~lvl_d;

  // a line cannot show a new edge on two consecutive cycles
  p_single_edge_r3: assert property (@(posedge clk) disable iff (rst)
    (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/irq_line_slice.sv
module irq_line_slice
  import irq_pend_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  line_ctl_t ctl,
  output logic      raw_q,
  output logic      act_q,
  output logic      mask_q,
  output logic      en_hit
);
  logic mask_n, raw_set, kill_raw, kill_act, en_ok;

  always_comb begin
    en_ok    = ctl.en & ~ctl.dis;
    mask_n   = (mask_q | ctl.en) & ~ctl.dis;
    raw_set  = raw_q | ctl.set_evt;
    kill_raw = ctl.clr | ctl.clr_all | (ctl.clr_en & mask_q);
    kill_act = ctl.clr | ctl.clr_all | ctl.clr_en;
    en_hit   = en_ok & raw_set & ~kill_act;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q  <= 1'b0;
      act_q  <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      mask_q <= mask_n;
      raw_q  <= raw_set & ~kill_raw;
      act_q  <= (act_q | (raw_set & en_ok) | (ctl.set_evt & mask_n)) & ~kill_act;
    end
  end

  p_pulse_raw_r1: assert property (@(posedge clk) disable iff (rst)
    (ctl.set_evt && !ctl.clr && !ctl.clr_all && !(ctl.clr_en && mask_q)) |=> raw_q);
  p_masked_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (!act_q && !mask_q && !ctl.en) |=> !act_q);
  p_enable_pending_r2: assert property (@(posedge clk) disable iff (rst)
    (ctl.en && !ctl.dis && raw_q && !ctl.clr && !ctl.clr_all && !ctl.clr_en) |=> act_q);
  p_clear_line_r5: assert property (@(posedge clk) disable iff (rst)
    ctl.clr |=> (!raw_q && !act_q));
  p_clear_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (ctl.clr && ctl.set_evt) |=> !raw_q);
  p_disable_wins_r10: assert property (@(posedge clk) disable iff (rst)
    ctl.dis |=> !mask_q);
  p_clr_en_act_r6: assert property (@(posedge clk) disable iff (rst)
    ctl.clr_en |=> !act_q);
  p_clr_en_keep_r6: assert property (@(posedge clk) disable iff (rst)
    (ctl.clr_en && !mask_q && raw_q && !ctl.clr && !ctl.clr_all) |=> raw_q);
endmodule

// File: rtl/irq_wake_ctl.sv
module irq_wake_ctl (
  input  logic clk,
  input  logic rst,
  input  logic lock_q,
  input  logic hw_any,
  input  logic hard_evt,
  input  logic en_hit_any,
  input  logic unlock,
  input  logic act_any,
  output logic wake_q
);
  logic wake_n;

  always_comb
    wake_n = hard_evt | (~lock_q & (hw_any | en_hit_any)) | (unlock & act_any);

  always_ff @(posedge clk) begin
    if (rst) wake_q <= 1'b0;
    else     wake_q <= wake_n;
  end

  p_lock_silent_r7: assert property (@(posedge clk) disable iff (rst)
    (lock_q && !hard_evt && !unlock) |=> !wake_q);
  p_unlock_wake_r7: assert property (@(posedge clk) disable iff (rst)
    (unlock && act_any) |=> wake_q);
  p_hw_wake_r8: assert property (@(posedge clk) disable iff (rst)
    (!lock_q && hw_any) |=> wake_q);
  p_hard_bypass_r9: assert property (@(posedge clk) disable iff (rst)
    hard_evt |=> wake_q);
endmodule

// File: rtl/irq_pend_unit.sv
module irq_pend_unit
  import irq_pend_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int IDX_W     = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] evt_pulse,
  input  logic [NUM_LINES-1:0] lvl_in,
  input  logic                 hard_evt,
  input  logic                 en_stb,
  input  logic [IDX_W-1:0]     en_idx,
  input  logic                 dis_stb,
  input  logic [IDX_W-1:0]     dis_idx,
  input  logic                 clr_stb,
  input  logic [IDX_W-1:0]     clr_idx,
  input  logic                 clr_all,
  input  logic                 clr_enabled,
  input  logic                 reeval_stb,
  input  logic [IDX_W-1:0]     reeval_idx,
  input  logic                 lock_stb,
  input  logic                 lock_val,
  output logic [NUM_LINES-1:0] raw_pend,
  output logic [NUM_LINES-1:0] act_pend,
  output logic [NUM_LINES-1:0] mask_o,
  output logic                 wake,
  output logic                 lock_o,
  output logic                 lock_prev
);
  localparam int LINES_OK = (NUM_LINES <= MAX_LINES) ? 1 : 0;

  logic [NUM_LINES-1:0] rise, hw_vec, en_hit;
  logic                 lock_q, prev_q, unlock;

  irq_level_edge #(.NUM_LINES(NUM_LINES)) u_edge (
    .clk(clk), .rst(rst), .lvl_in(lvl_in), .rise_o(rise)
  );

  assign hw_vec = evt_pulse | rise;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    line_ctl_t ctl;
    always_comb begin
      ctl.set_evt = hw_vec[i] | (reeval_stb && reeval_idx == IDX_W'(i) && lvl_in[i]);
      ctl.en      = en_stb  && en_idx  == IDX_W'(i);
      ctl.dis     = dis_stb && dis_idx == IDX_W'(i);
      ctl.clr     = clr_stb && clr_idx == IDX_W'(i);
      ctl.clr_en  = clr_enabled;
      ctl.clr_all = clr_all;
    end
    irq_line_slice u_slice (
      .clk(clk), .rst(rst), .ctl(ctl),
      .raw_q(raw_pend[i]), .act_q(act_pend[i]), .mask_q(mask_o[i]),
      .en_hit(en_hit[i])
    );
  end

  assign unlock = lock_stb & ~lock_val & lock_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= 1'b0;
      prev_q <= 1'b0;
    end else if (lock_stb) begin
      lock_q <= lock_val;
      prev_q <= lock_q;
    end
  end

  irq_wake_ctl u_wake (
    .clk(clk), .rst(rst), .lock_q(lock_q), .hw_any(|hw_vec),
    .hard_evt(hard_evt), .en_hit_any(|en_hit), .unlock(unlock),
    .act_any(|act_pend), .wake_q(wake)
  );

  assign lock_o    = lock_q;
  assign lock_prev = prev_q;

  initial p_width_ok_r12: assert (LINES_OK == 1);

  p_lock_prev_r11: assert property (@(posedge clk) disable iff (rst)
    lock_stb |=> (lock_prev == $past(lock_q)));
  p_lock_write_r11: assert property (@(posedge clk) disable iff (rst)
    lock_stb |=> (lock_o == $past(lock_val)));
  p_level_held_r3: assert property (@(posedge clk) disable iff (rst)
    (clr_all && !(|evt_pulse) && !reeval_stb) |=> ((raw_pend & ~$past(rise)) == '0));
endmodule

// File: tb/sim_irq_pend_unit.sv
`timescale 1ns/1ps
module sim_irq_pend_unit;
  localparam int N  = 16;
  localparam int IW = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic [N-1:0] evt_pulse, lvl_in;
  logic hard_evt, en_stb, dis_stb, clr_stb, clr_all, clr_enabled, reeval_stb, lock_stb, lock_val;
  logic [IW-1:0] en_idx, dis_idx, clr_idx, reeval_idx;
  logic [N-1:0] raw_pend, act_pend, mask_o;
  logic wake, lock_o, lock_prev;

  int checks = 0, errors = 0;

  // behavioural model state
  logic [N-1:0] m_raw, m_act, m_mask, m_lvl_d;
  logic m_lock, m_prev, m_wake;

  always #5 clk = ~clk;

  irq_pend_unit #(.NUM_LINES(N), .IDX_W(IW)) u0 (
    .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .lvl_in(lvl_in), .hard_evt(hard_evt),
    .en_stb(en_stb), .en_idx(en_idx), .dis_stb(dis_stb), .dis_idx(dis_idx),
    .clr_stb(clr_stb), .clr_idx(clr_idx), .clr_all(clr_all), .clr_enabled(clr_enabled),
    .reeval_stb(reeval_stb), .reeval_idx(reeval_idx), .lock_stb(lock_stb), .lock_val(lock_val),
    .raw_pend(raw_pend), .act_pend(act_pend), .mask_o(mask_o), .wake(wake),
    .lock_o(lock_o), .lock_prev(lock_prev)
  );

  task automatic check(input string tag, input string what, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic idle();
    evt_pulse = '0; hard_evt = 0; en_stb = 0; dis_stb = 0; clr_stb = 0;
    clr_all = 0; clr_enabled = 0; reeval_stb = 0; lock_stb = 0; lock_val = 0;
    en_idx = '0; dis_idx = '0; clr_idx = '0; reeval_idx = '0;
  endtask

  function automatic logic [N-1:0] bit_of(input logic [IW-1:0] i);
    return N'(1) << i;
  endfunction

  // one clock: model predicts from requirements, then all outputs compared
  task automatic step(input string tag);
    logic [N-1:0] rise, setv, env, disv, clrv, mask_n, raw_set, kill_raw, kill_act, hit;
    logic w;
    rise    = lvl_in & ~m_lvl_d;
    setv    = evt_pulse | rise | (reeval_stb ? (bit_of(reeval_idx) & lvl_in) : '0);
    env     = en_stb  ? bit_of(en_idx)  : '0;
    disv    = dis_stb ? bit_of(dis_idx) : '0;
    clrv    = clr_stb ? bit_of(clr_idx) : '0;
    mask_n  = (m_mask | env) & ~disv;
    raw_set = m_raw | setv;
    kill_raw = clrv | {N{clr_all}} | (clr_enabled ? m_mask : '0);
    kill_act = clrv | {N{clr_all | clr_enabled}};
    hit     = env & ~disv & raw_set & ~kill_act;
    w = hard_evt | (!m_lock && ((|(evt_pulse | rise)) || (|hit)))
        | (lock_stb && !lock_val && m_lock && (|m_act));
    @(posedge clk);
    m_act  = (m_act | (raw_set & env & ~disv) | (setv & mask_n)) & ~kill_act;
    m_raw  = raw_set & ~kill_raw;
    m_mask = mask_n;
    m_lvl_d = lvl_in;
    if (lock_stb) begin m_prev = m_lock; m_lock = lock_val; end
    m_wake = w;
    @(negedge clk);
    check(tag, "raw", 64'(raw_pend), 64'(m_raw));
    check(tag, "act", 64'(act_pend), 64'(m_act));
    check(tag, "mask", 64'(mask_o), 64'(m_mask));
    check(tag, "wake", 64'(wake), 64'(m_wake));
    check(tag, "lock", 64'(lock_o), 64'(m_lock));
    check(tag, "prev", 64'(lock_prev), 64'(m_prev));
    idle();
  endtask

  initial begin
    #(200000 * 10);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h1d2c;
    void'($urandom(seed));
    idle(); lvl_in = '0;
    m_raw = '0; m_act = '0; m_mask = '0; m_lvl_d = '0; m_lock = 0; m_prev = 0; m_wake = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R12 reset state
    check("R12", "raw", 64'(raw_pend), 64'h0);
    check("R12", "act", 64'(act_pend), 64'h0);
    check("R12", "wake", 64'(wake), 64'h0);
    check("R12", "lock", 64'({lock_o, lock_prev}), 64'h0);

    // R1 R8 masked pulse: raw only, wake anyway
    evt_pulse = 16'h0008; step("R1");
    check("R8", "wake masked", 64'(wake), 64'h1);
    check("R1", "act masked", 64'(act_pend[3]), 64'h0);
    // R2 enable pending line
    en_stb = 1; en_idx = 3; step("R2");
    check("R2", "act after enable", 64'(act_pend[3]), 64'h1);
    check("R2", "wake after enable", 64'(wake), 64'h1);
    // R2 disable keeps act
    dis_stb = 1; dis_idx = 3; step("R2");
    check("R2", "act kept on disable", 64'(act_pend[3]), 64'h1);
    // R11 R7 lock, pulse while locked
    lock_stb = 1; lock_val = 1; step("R11");
    check("R11", "prev", 64'(lock_prev), 64'h0);
    evt_pulse = 16'h0020; step("R7");
    check("R7", "no wake locked", 64'(wake), 64'h0);
    en_stb = 1; en_idx = 5; step("R2");
    check("R2", "locked enable no wake", 64'(wake), 64'h0);
    check("R2", "locked enable act", 64'(act_pend[5]), 64'h1);
    // R7 unlock with work waiting
    lock_stb = 1; lock_val = 0; step("R7");
    check("R7", "unlock wake", 64'(wake), 64'h1);
    check("R11", "prev after unlock", 64'(lock_prev), 64'h1);
    // R10 clear beats set, R5 clear line
    en_stb = 1; en_idx = 4; evt_pulse = 16'h0010; step("R1");
    check("R1", "unmasked act", 64'(act_pend[4]), 64'h1);
    clr_stb = 1; clr_idx = 4; evt_pulse = 16'h0010; step("R10");
    check("R5", "cleared", 64'({raw_pend[4], act_pend[4]}), 64'h0);
    en_stb = 1; en_idx = 6; dis_stb = 1; dis_idx = 6; step("R10");
    check("R10", "disable wins", 64'(mask_o[6]), 64'h0);
    // R3 level line
    en_stb = 1; en_idx = 7; step("R3");
    lvl_in[7] = 1; step("R3");
    check("R3", "rise act", 64'(act_pend[7]), 64'h1);
    clr_stb = 1; clr_idx = 7; step("R5");
    step("R3"); step("R3");
    check("R3", "held no repend", 64'(raw_pend[7]), 64'h0);
    // R4 reeval while high
    reeval_stb = 1; reeval_idx = 7; step("R4");
    check("R4", "reeval act", 64'(act_pend[7]), 64'h1);
    check("R4", "reeval no wake", 64'(wake), 64'h0);
    lvl_in[7] = 0; clr_stb = 1; clr_idx = 7; step("R4");
    reeval_stb = 1; reeval_idx = 7; step("R4");
    check("R4", "reeval low", 64'(raw_pend[7]), 64'h0);
    // R6 clear enabled keeps masked raw
    evt_pulse = 16'h0200; step("R6");
    clr_enabled = 1; step("R6");
    check("R6", "masked raw kept", 64'(raw_pend[9]), 64'h1);
    check("R6", "act zero", 64'(act_pend), 64'h0);
    clr_all = 1; step("R6");
    check("R6", "all clear", 64'(raw_pend), 64'h0);
    // R9 hard bypass
    lock_stb = 1; lock_val = 1; step("R9");
    hard_evt = 1; step("R9");
    check("R9", "hard wake", 64'(wake), 64'h1);
    evt_pulse = 16'h0001; step("R9");
    check("R9", "single bypass", 64'(wake), 64'h0);
    lock_stb = 1; lock_val = 0; step("R7");

    // random mix
    for (int k = 0; k < 4000; k++) begin
      evt_pulse = ($urandom % 4 == 0) ? N'($urandom) & N'($urandom) : '0;
      if ($urandom % 6 == 0) lvl_in = lvl_in ^ (N'(1) << ($urandom % N));
      hard_evt   = ($urandom % 40 == 0);
      en_stb     = ($urandom % 4 == 0);  en_idx  = IW'($urandom);
      dis_stb    = ($urandom % 6 == 0);  dis_idx = IW'($urandom);
      clr_stb    = ($urandom % 5 == 0);  clr_idx = IW'($urandom);
      clr_all    = ($urandom % 60 == 0);
      clr_enabled= ($urandom % 30 == 0);
      reeval_stb = ($urandom % 5 == 0);  reeval_idx = IW'($urandom);
      lock_stb   = ($urandom % 10 == 0); lock_val = $urandom % 2;
      step("R1 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule